// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a logical address, made of a segment selector and an offset, into a linear address. It keeps two small descriptor tables, one local and one global. The top bit of the selector picks the table and the lower bits pick the entry. Each entry holds a base, a length (limit), a valid flag and three access rights: read, write and execute. Each table has its own length register, which bounds how many of its entries may be used.

Software-side logic loads the entries through an entry write port and the table lengths through a length write port. A request names the selector, the offset and the access kind. One cycle later the block returns either the base plus the offset, or a single fault code. When several checks fail at once, the fault code is the one with the highest priority.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, rsp_valid is 0, every entry is invalid and both table lengths are 0. Any request made before loading therefore gets a bounds fault.
- R2: A request accepted in cycle N produces a response with rsp_valid = 1 in cycle N+1. A cycle with no request produces rsp_valid = 0 in the following cycle.
- R3: Selector bit IDX_W picks the table: 0 is local and 1 is global. Bits IDX_W-1:0 pick the entry. The two tables are independent.
- R4: An entry index greater than or equal to the chosen table's length gives fault code 1 (bounds).
- R5: A bounds-passing entry whose valid flag is 0 gives fault code 2 (invalid).
- R6: An offset greater than or equal to the entry's limit gives fault code 3 (limit). An offset of limit-1 is accepted.
- R7: The access kind is encoded as 0 = read, 1 = write, 2 = execute, 3 = reserved. Rights bit 0 grants read, bit 1 grants write and bit 2 grants execute. A kind whose rights bit is clear, or kind 3, gives fault code 4 (privilege).
- R8: When no check fails, rsp_addr = (base + offset) mod 2^ADDR_W, rsp_code = 0 and rsp_fault = 0.
- R9: Fault priority runs bounds > invalid > limit > privilege. Only the highest failing code is reported, and rsp_fault is 1 exactly when rsp_code is nonzero.
- R10: On any fault, rsp_addr is 0.
- R11: A request in the same cycle as a write to its entry or its table length sees the old contents. Requests in later cycles see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry write strobe |
| wr_tsel | input | 1 | Table for the entry write (1 = global) |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_base | input | ADDR_W | Base to store |
| wr_limit | input | OFF_W | Segment length to store |
| wr_valid | input | 1 | Valid flag to store |
| wr_perm | input | 3 | Rights to store {exec, write, read} |
| len_en | input | 1 | Table length write strobe |
| len_tsel | input | 1 | Table for the length write |
| len_val | input | IDX_W+1 | New table length |
| req_valid | input | 1 | Translation request |
| req_sel | input | IDX_W+1 | Segment selector {table, index} |
| req_off | input | OFF_W | Offset within the segment |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | ADDR_W | Linear address, or 0 on a fault |
| rsp_fault | output | 1 | A fault was raised |
| rsp_code | output | 3 | 0 none, 1 bounds, 2 invalid, 3 limit, 4 privilege |

## Verification
Directed requests place one offset below the limit and one exactly at it. Each access kind is run against entries that grant a single right, so a wrong rights bit mapping shows up. Stacked faults, such as an invalid entry that also has an offset past its limit and a missing right, tell the priority order apart from any single check. Requests are issued on both tables with the same index, a base near the top of the address space exercises wraparound, and a write is issued in the same cycle as a request to its entry. A long random run, which also mixes in writes, is compared on every clock against a behavioural model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_BOUNDS  = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PRIV    = 3'd4
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  // Rights: bit0 read, bit1 write, bit2 execute; kind 3 is never granted.
  function automatic logic kind_granted(input logic [2:0] perm, input logic [1:0] kind);
    case (kind)
      ACC_READ:  return perm[0];
      ACC_WRITE: return perm[1];
      ACC_EXEC:  return perm[2];
      default:   return 1'b0;
    endcase
  endfunction

  // Priority encoder over the four checks.
  function automatic fault_e pick_fault(input logic b, input logic i,
                                        input logic l, input logic p);
    if (b)      return FLT_BOUNDS;
    else if (i) return FLT_INVALID;
    else if (l) return FLT_LIMIT;
    else if (p) return FLT_PRIV;
    else        return FLT_NONE;
  endfunction

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_tsel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [2:0]        wr_perm,
  input  logic              len_en,
  input  logic              len_tsel,
  input  logic [IDX_W:0]    len_val,
  input  logic              rd_tsel,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_limit,
  output logic              rd_valid,
  output logic [2:0]        rd_perm,
  output logic [IDX_W:0]    rd_len
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int NTABLES = 2;

  logic [ADDR_W-1:0] base_q  [NTABLES][DEPTH];
  logic [OFF_W-1:0]  limit_q [NTABLES][DEPTH];
  logic              valid_q [NTABLES][DEPTH];
  logic [2:0]        perm_q  [NTABLES][DEPTH];
  logic [IDX_W:0]    len_q   [NTABLES];

  for (genvar t = 0; t < NTABLES; t++) begin : g_tbl
    logic wr_hit, len_hit;
    assign wr_hit  = wr_en  && (wr_tsel  == t[0]);
    assign len_hit = len_en && (len_tsel == t[0]);

    always_ff @(posedge clk) begin
      if (!rst_n) len_q[t] <= '0;
      else if (len_hit) len_q[t] <= len_val;
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          base_q[t][e]  <= '0;
          limit_q[t][e] <= '0;
          valid_q[t][e] <= 1'b0;
          perm_q[t][e]  <= '0;
        end else if (wr_hit && (wr_idx == e[IDX_W-1:0])) begin
          base_q[t][e]  <= wr_base;
          limit_q[t][e] <= wr_limit;
          valid_q[t][e] <= wr_valid;
          perm_q[t][e]  <= wr_perm;
        end
      end
    end
  end

  assign rd_base  = base_q[rd_tsel][rd_idx];
  assign rd_limit = limit_q[rd_tsel][rd_idx];
  assign rd_valid = valid_q[rd_tsel][rd_idx];
  assign rd_perm  = perm_q[rd_tsel][rd_idx];
  assign rd_len   = len_q[rd_tsel];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int OFF_W = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W:0]   tbl_len,
  input  logic             ent_valid,
  input  logic [OFF_W-1:0] ent_limit,
  input  logic [2:0]       ent_perm,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       kind,
  output logic             bounds_hit,
  output logic             inval_hit,
  output logic             limit_hit,
  output logic             priv_hit
);
  assign bounds_hit = ({1'b0, idx} >= tbl_len);
  assign inval_hit  = !ent_valid;
  assign limit_hit  = (off >= ent_limit);
  assign priv_hit   = !kind_granted(ent_perm, kind);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_tsel,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [2:0]        wr_perm,
  input  logic              len_en,
  input  logic              len_tsel,
  input  logic [IDX_W:0]    len_val,
  input  logic              req_valid,
  input  logic [IDX_W:0]    req_sel,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic [2:0]        rsp_code
);
  localparam int SEL_W = IDX_W + 1;

  function automatic logic [ADDR_W-1:0] linear_of(input logic [ADDR_W-1:0] base,
                                                  input logic [OFF_W-1:0] off);
    logic [ADDR_W-1:0] wide_off;
    wide_off = ADDR_W'(off);
    return base + wide_off;
  endfunction

  logic              sel_tbl;
  logic [IDX_W-1:0]  sel_idx;
  logic [ADDR_W-1:0] ent_base;
  logic [OFF_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [2:0]        ent_perm;
  logic [IDX_W:0]    tbl_len;
  logic              bounds_hit, inval_hit, limit_hit, priv_hit;
  fault_e            fault_n;

  assign sel_tbl = req_sel[SEL_W-1];
  assign sel_idx = req_sel[IDX_W-1:0];

  seg_desc_table #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tsel(wr_tsel), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_valid(wr_valid), .wr_perm(wr_perm),
    .len_en(len_en), .len_tsel(len_tsel), .len_val(len_val),
    .rd_tsel(sel_tbl), .rd_idx(sel_idx),
    .rd_base(ent_base), .rd_limit(ent_limit), .rd_valid(ent_valid),
    .rd_perm(ent_perm), .rd_len(tbl_len)
  );

  seg_check #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk_logic (
    .idx(sel_idx), .tbl_len(tbl_len), .ent_valid(ent_valid),
    .ent_limit(ent_limit), .ent_perm(ent_perm), .off(req_off), .kind(req_kind),
    .bounds_hit(bounds_hit), .inval_hit(inval_hit),
    .limit_hit(limit_hit), .priv_hit(priv_hit)
  );

  assign fault_n = pick_fault(bounds_hit, inval_hit, limit_hit, priv_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_fault <= 1'b0;
      rsp_code  <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= (fault_n != FLT_NONE);
        rsp_code  <= fault_n;
        rsp_addr  <= (fault_n == FLT_NONE) ? linear_of(ent_base, req_off) : '0;
      end else begin
        rsp_fault <= 1'b0;
        rsp_code  <= FLT_NONE;
        rsp_addr  <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [2:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              bounds_hit,
  input logic              inval_hit,
  input logic              limit_hit,
  input logic              priv_hit
);
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_bounds_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && bounds_hit) |=> (rsp_code == 3'd1));
  p_invalid_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bounds_hit && inval_hit) |=> (rsp_code == 3'd2));
  p_limit_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bounds_hit && !inval_hit && limit_hit) |=> (rsp_code == 3'd3));
  p_priv_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bounds_hit && !inval_hit && !limit_hit && priv_hit) |=> (rsp_code == 3'd4));
  p_clean_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !bounds_hit && !inval_hit && !limit_hit && !priv_hit) |=> !rsp_fault);
  p_flag_matches_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));
  p_fault_zero_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 3, OFF_W = 16, ADDR_W = 24;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_tsel = 0, wr_valid = 0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [ADDR_W-1:0] wr_base = '0;
  logic [OFF_W-1:0] wr_limit = '0;
  logic [2:0] wr_perm = '0;
  logic len_en = 0, len_tsel = 0;
  logic [IDX_W:0] len_val = '0;
  logic req_valid = 0;
  logic [IDX_W:0] req_sel = '0;
  logic [OFF_W-1:0] req_off = '0;
  logic [1:0] req_kind = '0;
  logic rsp_valid, rsp_fault;
  logic [ADDR_W-1:0] rsp_addr;
  logic [2:0] rsp_code;

  int total = 0, bad = 0;
  int m_base[2][DEPTH], m_lim[2][DEPTH], m_perm[2][DEPTH], m_len[2];
  bit m_ok[2][DEPTH];

  seg_xlate_unit #(.IDX_W(IDX_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic void model_eval(output int code, output int addr);
    int t, i, o, k;
    t = int'(req_sel[IDX_W]); i = int'(req_sel[IDX_W-1:0]);
    o = int'(req_off); k = int'(req_kind);
    addr = 0;
    if (i >= m_len[t]) code = 1;
    else if (!m_ok[t][i]) code = 2;
    else if (o >= m_lim[t][i]) code = 3;
    else if (k == 3 || ((m_perm[t][i] >> k) & 1) == 0) code = 4;
    else begin code = 0; addr = (m_base[t][i] + o) % (1 << ADDR_W); end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs already driven; advance one clock, update model, compare.
  task automatic step(input string tag);
    int ec, ea; bit ev;
    ev = req_valid;
    model_eval(ec, ea);
    @(posedge clk);
    if (wr_en) begin
      m_base[wr_tsel][wr_idx] = int'(wr_base); m_lim[wr_tsel][wr_idx] = int'(wr_limit);
      m_ok[wr_tsel][wr_idx] = wr_valid; m_perm[wr_tsel][wr_idx] = int'(wr_perm);
    end
    if (len_en) m_len[len_tsel] = int'(len_val);
    @(negedge clk);
    check({tag, " valid"}, int'(rsp_valid), int'(ev));
    if (ev) begin
      check({tag, " code"}, int'(rsp_code), ec);
      check({tag, " fault"}, int'(rsp_fault), int'(ec != 0));
      check({tag, " addr"}, int'(rsp_addr), ea);
    end
  endtask

  task automatic put_ent(input bit t, input int i, input int b, input int l, input bit v, input int p);
    wr_en = 1; wr_tsel = t; wr_idx = IDX_W'(i); wr_base = ADDR_W'(b);
    wr_limit = OFF_W'(l); wr_valid = v; wr_perm = 3'(p);
    step("R11 load");
    wr_en = 0;
  endtask

  task automatic ask(input string tag, input bit t, input int i, input int o, input int k);
    req_valid = 1; req_sel = {t, IDX_W'(i)}; req_off = OFF_W'(o); req_kind = 2'(k);
    step(tag);
    req_valid = 0;
  endtask

  initial begin
    for (int t = 0; t < 2; t++) begin
      m_len[t] = 0;
      for (int e = 0; e < DEPTH; e++) begin m_base[t][e]=0; m_lim[t][e]=0; m_perm[t][e]=0; m_ok[t][e]=0; end
    end
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(rsp_valid), 0);
    rst_n = 1;
    ask("R1 empty table bounds", 0, 0, 0, 0);
    // lengths: local 4, global 6
    len_en = 1; len_tsel = 0; len_val = 4'd4; step("R11 len"); 
    len_tsel = 1; len_val = 4'd6; step("R11 len"); len_en = 0;
    put_ent(0, 0, 'h1000, 'h100, 1, 1);      // read only
    put_ent(0, 1, 'hFFFF00, 'h200, 1, 7);    // near top, all rights
    put_ent(0, 2, 'h5000, 'h10, 0, 7);       // invalid
    put_ent(0, 3, 'h7000, 0, 1, 3);          // zero length
    put_ent(1, 0, 'h20000, 'h40, 1, 4);      // exec only
    put_ent(1, 5, 'h30000, 'h80, 1, 2);      // write only
    ask("R8 read ok", 0, 0, 'h10, 0);
    ask("R6 last byte ok", 0, 0, 'hFF, 0);
    ask("R6 at limit", 0, 0, 'h100, 0);
    ask("R7 write on read-only", 0, 0, 'h10, 1);
    ask("R7 exec on read-only", 0, 0, 'h10, 2);
    ask("R7 reserved kind", 0, 1, 0, 3);
    ask("R8 wraparound", 0, 1, 'h150, 0);
    ask("R5 invalid entry", 0, 2, 0, 0);
    ask("R9 invalid beats limit and priv", 0, 2, 'hFFFF, 3);
    ask("R6 zero length", 0, 3, 0, 0);
    ask("R4 local past length", 0, 4, 0, 0);
    ask("R9 bounds beats all", 0, 7, 'hFFFF, 3);
    ask("R3 global exec", 1, 0, 'h3F, 2);
    ask("R3 global read denied", 1, 0, 'h3F, 0);
    ask("R9 limit beats priv", 1, 0, 'h40, 0);
    ask("R7 write-only write", 1, 5, 'h7F, 1);
    ask("R4 global at length", 1, 6, 0, 0);
    req_valid = 0; step("R2 idle");
    // same-cycle write and request
    wr_en = 1; wr_tsel = 0; wr_idx = 3'd2; wr_base = 'h5000; wr_limit = 'h10; wr_valid = 1; wr_perm = 3'd1;
    req_valid = 1; req_sel = {1'b0, 3'd2}; req_off = 'h4; req_kind = 0;
    step("R11 same cycle sees old");
    wr_en = 0;
    step("R11 next cycle sees new");
    len_en = 1; len_tsel = 1; len_val = 4'd0; req_sel = {1'b1, 3'd0}; req_kind = 2;
    step("R11 len same cycle");
    len_en = 0; step("R11 len applied");
    req_valid = 0;
    for (int n = 0; n < 400; n++) begin
      wr_en = ($urandom % 4) == 0; wr_tsel = 1'($urandom); wr_idx = IDX_W'($urandom);
      wr_base = ADDR_W'($urandom); wr_limit = OFF_W'($urandom % 512); wr_valid = ($urandom % 4) != 0;
      wr_perm = 3'($urandom);
      len_en = ($urandom % 8) == 0; len_tsel = 1'($urandom); len_val = 4'($urandom % 10);
      req_valid = ($urandom % 5) != 0; req_sel = 4'($urandom);
      req_off = OFF_W'($urandom % 600); req_kind = 2'($urandom);
      step("R9 random");
    end
    wr_en = 0; len_en = 0; req_valid = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule